// File: doc/BRIEF.md
# Four-Common LCD Drive Level Sequencer

This block produces the drive-level codes for a 1/3-bias, four-way multiplexed liquid crystal panel: four common lines and a parameterised number of segment lines. Each output is a 2-bit level code from 0 to 3, one code per third of the panel supply, which analog drivers outside the block turn into voltages. A frame is split into eight phases. Each common is active for two consecutive phases, at the top level in the first of the pair and at the bottom level in the second, so every pixel sees a voltage with no DC part over a frame.

Phases advance on a slow LCD tick supplied from outside. At each phase start the block samples a bitmap of four bits per segment, one bit for each pairing of that segment with a common, and drives each segment opposite the active common (pixel on) or near it (pixel off). An optional pre-drive parks every segment at the level of the idle commons for one to three clocks at the start of each phase before it moves to its final level. This splits large swings in two and lowers the peak charge drawn from the bias supply.

Top module: `lcd_mux4_wavegen`

## Requirements
- R1: While reset is high, and from the second clock edge after enable is sampled low, every common and segment output is 0; re-enabling restarts the frame at phase 0.
- R2: The first clock with enable high after a disabled period starts phase 0, and each tick sampled while running starts the next phase, 7 wrapping to 0; outputs follow one clock after the edge that starts a phase.
- R3: In phase p the active common is p/2 (rounded down), at level 3 when p is even and at level 0 when p is odd; the other three commons sit at 2 in even phases and at 1 in odd phases.
- R4: A segment whose pixel is on for the active common is driven to 0 in even phases and to 3 in odd phases once any pre-drive has ended.
- R5: A segment whose pixel is off is driven to 2 in even phases and to 1 in odd phases once any pre-drive has ended.
- R6: The pixel bit for segment s and common k is bitmap bit 4*s+k; the bitmap is sampled only at the edge that starts a phase, and changes later in the phase have no effect on the outputs.
- R7: With pre-drive on and a length L of 1 to 3, every segment sits at the idle-common level (2 in even phases, 1 in odd phases) for the first L output cycles of each phase, then takes its final level.
- R8: A length of 0, or pre-drive off, gives final segment levels from the first output cycle of the phase.
- R9: A tick that arrives while segments are still parked starts the next phase at once, with a fresh park period of the newly sampled length.
- R10: The pre-drive enable and length are sampled at the phase start edge only; changing them mid-phase does not alter the current phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; low holds all outputs at level 0 |
| tick | input | 1 | One-clock pulse that starts the next phase |
| park_en | input | 1 | Enables the segment pre-drive at each phase start |
| park_len | input | 2 | Pre-drive length in clocks (0 means none) |
| seg_map | input | 4*NSEG | Pixel bitmap, bit 4*s+k for segment s and common k |
| com_lvl | output | 8 | Common level codes, bits 2k+1:2k for common k |
| seg_lvl | output | 2*NSEG | Segment level codes, bits 2s+1:2s for segment s |

## Verification
The main function runs under random bitmaps with sparse ticks, so that every phase parity meets on and off pixels and R3 to R6 separate the common-to-segment pairing from the level polarity. Runs with ticks one or two clocks apart hit the case where a new phase begins while segments are still parked, which tells a restarting park counter from one that runs on. Directed runs cover disable with ticks present, a full frame that wraps from phase 7, length 0 with pre-drive on, and bitmap or length changes in mid-phase that must leave the outputs alone.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

  typedef logic [1:0] lvl_t;

  localparam int unsigned NCOM    = 4;
  localparam int unsigned NPHASE  = 2 * NCOM;
  localparam int unsigned PH_W    = $clog2(NPHASE);

  // Level of the three commons that are not active in this phase.
  function automatic lvl_t idle_level(input logic odd);
    return odd ? 2'd1 : 2'd2;
  endfunction

  // Level of the active common in this phase.
  function automatic lvl_t active_level(input logic odd);
    return odd ? 2'd0 : 2'd3;
  endfunction

  // Final segment level: opposite the active common when on,
  // one third away from it when off.
  function automatic lvl_t seg_final(input logic odd, input logic on);
    if (on) return odd ? 2'd3 : 2'd0;
    return idle_level(odd);
  endfunction

endpackage

// File: rtl/lcd4_phase_seq.sv
module lcd4_phase_seq
  import lcd4_pkg::*;
#(
  parameter int unsigned LEN_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic            park_en,
  input  logic [LEN_W-1:0] park_len,
  output logic            start,
  output logic            run_q,
  output logic [PH_W-1:0] phase_q,
  output logic            park_q
);

  logic [LEN_W-1:0] rcnt_q;

  // A phase begins on the first enabled clock or on a tick while running.
  assign start  = en & (~run_q | tick);
  assign park_q = (rcnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      rcnt_q  <= '0;
    end else begin
      run_q <= 1'b1;
      if (start) begin
        phase_q <= run_q ? phase_q + 1'b1 : '0;
        rcnt_q  <= park_en ? park_len : '0;
      end else if (rcnt_q != '0) begin
        rcnt_q <= rcnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd4_com_drv.sv
module lcd4_com_drv
  import lcd4_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PH_W-1:0]   phase,
  output logic [2*NCOM-1:0] com_lvl
);

  localparam int unsigned SEL_W = PH_W - 1;

  logic [SEL_W-1:0] act_sel;
  logic             odd;

  assign act_sel = phase[PH_W-1:1];
  assign odd     = phase[0];

  for (genvar k = 0; k < NCOM; k++) begin : g_com
    lvl_t nxt;
    always_comb begin
      if (!run)                     nxt = 2'd0;
      else if (act_sel == SEL_W'(k)) nxt = active_level(odd);
      else                          nxt = idle_level(odd);
    end
    always_ff @(posedge clk) begin
      if (rst) com_lvl[2*k +: 2] <= 2'd0;
      else     com_lvl[2*k +: 2] <= nxt;
    end
  end

endmodule

// File: rtl/lcd4_seg_bank.sv
module lcd4_seg_bank
  import lcd4_pkg::*;
#(
  parameter int unsigned NSEG = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               run,
  input  logic [PH_W-1:0]    phase,
  input  logic               park,
  input  logic [NCOM*NSEG-1:0] seg_map,
  output logic [2*NSEG-1:0]  seg_lvl
);

  localparam int unsigned MAP_W = NCOM * NSEG;

  logic [MAP_W-1:0] map_q;
  logic [PH_W-2:0]  act_sel;
  logic             odd;

  assign act_sel = phase[PH_W-1:1];
  assign odd     = phase[0];

  // Bitmap is captured only at the edge that opens a phase.
  always_ff @(posedge clk) begin
    if (rst)        map_q <= '0;
    else if (start) map_q <= seg_map;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [NCOM-1:0] pix;
    lvl_t            nxt;
    assign pix = map_q[NCOM*s +: NCOM];
    always_comb begin
      if (!run)      nxt = 2'd0;
      else if (park) nxt = idle_level(odd);
      else           nxt = seg_final(odd, pix[act_sel]);
    end
    always_ff @(posedge clk) begin
      if (rst) seg_lvl[2*s +: 2] <= 2'd0;
      else     seg_lvl[2*s +: 2] <= nxt;
    end
  end

endmodule

// File: rtl/lcd_mux4_wavegen.sv
module lcd_mux4_wavegen
  import lcd4_pkg::*;
#(
  parameter int unsigned NSEG  = 8,
  parameter int unsigned LEN_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 tick,
  input  logic                 park_en,
  input  logic [LEN_W-1:0]     park_len,
  input  logic [4*NSEG-1:0]    seg_map,
  output logic [7:0]           com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl
);

  logic            start;
  logic            run_q;
  logic [PH_W-1:0] phase_q;
  logic            park_q;

  lcd4_phase_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .tick     (tick),
    .park_en  (park_en),
    .park_len (park_len),
    .start    (start),
    .run_q    (run_q),
    .phase_q  (phase_q),
    .park_q   (park_q)
  );

  lcd4_com_drv u_com (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .phase   (phase_q),
    .com_lvl (com_lvl)
  );

  lcd4_seg_bank #(.NSEG(NSEG)) u_seg (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .run     (run_q),
    .phase   (phase_q),
    .park    (park_q),
    .seg_map (seg_map),
    .seg_lvl (seg_lvl)
  );

endmodule

// File: rtl/lcd4_wavegen_chk.sv
module lcd4_wavegen_chk #(
  parameter int unsigned NSEG = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              tick,
  input logic [7:0]        com_lvl,
  input logic [2*NSEG-1:0] seg_lvl
);

  logic [3:0] extreme;
  logic       odd_seen;

  always_comb begin
    for (int k = 0; k < 4; k++)
      extreme[k] = (com_lvl[2*k +: 2] == 2'd0) || (com_lvl[2*k +: 2] == 2'd3);
    odd_seen = 1'b0;
    for (int k = 0; k < 4; k++)
      if (com_lvl[2*k +: 2] == 2'd0) odd_seen = 1'b1;
  end

  // R1: enable low two edges back forces every output to 0
  p_off_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(en, 2) && !$past(rst, 2)) |-> (com_lvl == '0 && seg_lvl == '0));

  // R3: exactly one common at an outer level while running
  p_one_active_r3: assert property (@(posedge clk) disable iff (rst)
    (com_lvl != '0) |-> ($countones(extreme) == 1));

  // R2: commons hold unless a tick or an enable change preceded
  p_com_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick, 2) && $past(en, 2) && $past(en, 3) &&
     !$past(rst) && !$past(rst, 2) && !$past(rst, 3)) |-> $stable(com_lvl));

  // R4 / R5 / R7: every segment level has the parity of the idle commons
  for (genvar s = 0; s < NSEG; s++) begin : g_par
    p_seg_parity_r5: assert property (@(posedge clk) disable iff (rst)
      (com_lvl != '0) |-> (seg_lvl[2*s] == odd_seen));
  end

endmodule

bind lcd_mux4_wavegen lcd4_wavegen_chk #(.NSEG(NSEG)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .tick    (tick),
  .com_lvl (com_lvl),
  .seg_lvl (seg_lvl)
);

// File: tb/test_lcd_mux4_wavegen.sv
module test_lcd_mux4_wavegen;

  localparam int NSEG = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              tick = 1'b0;
  logic              park_en = 1'b0;
  logic [1:0]        park_len = 2'd0;
  logic [4*NSEG-1:0] seg_map = '0;
  logic [7:0]        com_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  // reference state
  bit              m_run = 0;
  int              m_ph = 0;
  int              m_rc = 0;
  logic [4*NSEG-1:0] m_map = '0;
  logic [7:0]        e_com = '0;
  logic [2*NSEG-1:0] e_seg = '0;

  always #10 clk = ~clk;

  lcd_mux4_wavegen #(.NSEG(NSEG)) i_lcd_mux4_wavegen (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .park_en(park_en),
    .park_len(park_len), .seg_map(seg_map), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  function automatic logic [1:0] exp_com(int ph, int k);
    bit odd = ph[0];
    if (k == ph / 2) return odd ? 2'd0 : 2'd3;
    return odd ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [1:0] exp_seg(int ph, bit on, bit parked);
    bit odd = ph[0];
    if (parked || !on) return odd ? 2'd1 : 2'd2;
    return odd ? 2'd3 : 2'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // One clock: compare outputs of the last edge, drive inputs, step model.
  task automatic cyc(bit r, bit e, bit t, bit pe, logic [1:0] pl, logic [4*NSEG-1:0] mp);
    @(negedge clk);
    cycles++;
    check(tag, {24'd0, com_lvl}, {24'd0, e_com});
    check(tag, {16'd0, seg_lvl}, {16'd0, e_seg});
    rst = r; en = e; tick = t; park_en = pe; park_len = pl; seg_map = mp;
    if (r || !m_run) begin
      e_com = '0; e_seg = '0;
    end else begin
      for (int k = 0; k < 4; k++) e_com[2*k +: 2] = exp_com(m_ph, k);
      for (int s = 0; s < NSEG; s++)
        e_seg[2*s +: 2] = exp_seg(m_ph, m_map[4*s + m_ph/2], m_rc != 0);
    end
    if (r || !e) begin
      m_run = 0; m_ph = 0; m_rc = 0;
    end else begin
      if (!m_run || t) begin
        m_ph  = m_run ? (m_ph + 1) % 8 : 0;
        m_rc  = pe ? int'(pl) : 0;
        m_map = mp;
      end else if (m_rc != 0) begin
        m_rc--;
      end
      m_run = 1;
    end
  endtask

  task automatic idle(int n, bit pe, logic [1:0] pl, logic [4*NSEG-1:0] mp);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, pe, pl, mp);
  endtask

  initial begin
    void'($urandom(32'h1cd4));
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, '0);
    // R1: ticks while disabled have no effect
    for (int i = 0; i < 6; i++) cyc(0, 0, i[0], 1, 2'd2, 32'hffff_ffff);

    // R2, R3: full frame wrap with a fixed map, no park
    tag = "R2";
    cyc(0, 1, 0, 0, 0, 32'h1248_8421);
    for (int p = 0; p < 10; p++) begin
      tag = (p % 2) ? "R3" : "R2";
      idle(3, 0, 0, 32'h1248_8421);
      cyc(0, 1, 1, 0, 0, 32'h1248_8421);
    end

    // R4: all pixels on; R5: all pixels off
    tag = "R4";
    for (int p = 0; p < 8; p++) begin idle(2, 0, 0, '1); cyc(0, 1, 1, 0, 0, '1); end
    tag = "R5";
    for (int p = 0; p < 8; p++) begin idle(2, 0, 0, '0); cyc(0, 1, 1, 0, 0, '0); end

    // R6: map changes mid-phase must not show
    tag = "R6";
    for (int p = 0; p < 8; p++) begin
      cyc(0, 1, 1, 0, 0, 32'h5a5a_a5a5);
      cyc(0, 1, 0, 0, 0, ~32'h5a5a_a5a5);
      cyc(0, 1, 0, 0, 0, $urandom);
      cyc(0, 1, 0, 0, 0, $urandom);
    end

    // R7: park lengths 1..3
    tag = "R7";
    for (int l = 1; l < 4; l++)
      for (int p = 0; p < 4; p++) begin
        cyc(0, 1, 1, 1, 2'(l), 32'hf0f0_3c3c);
        idle(5, 1, 2'(l), 32'hf0f0_3c3c);
      end

    // R8: length 0 with enable bit set, and bit clear with length 3
    tag = "R8";
    for (int p = 0; p < 4; p++) begin cyc(0, 1, 1, 1, 2'd0, '1); idle(3, 1, 0, '1); end
    for (int p = 0; p < 4; p++) begin cyc(0, 1, 1, 0, 2'd3, '1); idle(3, 0, 3, '1); end

    // R9: ticks arriving during park
    tag = "R9";
    for (int p = 0; p < 12; p++) cyc(0, 1, 1, 1, 2'd3, $urandom);
    for (int p = 0; p < 8; p++) begin cyc(0, 1, 1, 1, 2'd3, '1); cyc(0, 1, 0, 1, 2'd3, '1); end

    // R10: park settings changed mid-phase
    tag = "R10";
    for (int p = 0; p < 6; p++) begin
      cyc(0, 1, 1, 1, 2'd1, '0);
      cyc(0, 1, 0, 1, 2'd3, '0);
      cyc(0, 1, 0, 0, 2'd0, '0);
      idle(3, 1, 2, '0);
    end

    // R1: disable in mid-frame, re-enable restarts at phase 0
    tag = "R1";
    idle(2, 1, 2, '1); cyc(0, 1, 1, 1, 2, '1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 2, '1);
    idle(6, 1, 2, '1);

    // random mix
    tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      automatic bit e = ($urandom % 50) != 0;
      automatic bit t = ($urandom % 5) == 0;
      cyc(0, e, t, $urandom % 2, 2'($urandom), $urandom);
    end
    cyc(0, 1, 0, 0, 0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule